// File: doc/BRIEF.md
# Video and CPU DRAM Address Translator

This block forms the DRAM address for every memory slot of a shared video/CPU memory. Each slot is either a processor access or a display fetch, and the half of the 2 MHz phase in which the slot falls decides which one it is. In a processor slot the 15-bit CPU address goes straight through. In a display slot the 14-bit character address from the display controller is rearranged. The top bit of that address picks one of two layouts. The teletext layout ignores the scanline counter and folds each screen into a 1K window. The bitmap layout places the 3-bit scanline counter in the low bits, so that consecutive bytes of one character are adjacent in memory.

In bitmap fetches the address can run past the end of memory. A 2-bit size code then subtracts the size of the display area from the upper address nibble, so the screen wraps back to its own start. This gives hardware scrolling without any copying. The result is registered on every slot edge, so it stays steady through the row and column phases that follow. All the block's edges are plain per-slot levels. A new address is accepted on every slot clock and none is ever refused, so there is no back-pressure to manage.

Top module: `vidmem_addr_xlate`

## Requirements
- R1: While rst_n is low, dram_addr is 0.
- R2: A slot with phase_2m low yields dram_addr equal to cpu_addr.
- R3: A slot with phase_2m high and disp_addr[13] high is a teletext fetch. In it, dram_addr[13:10] is 4'b1111, dram_addr[9:7] is disp_addr[9:7], dram_addr[5:0] is disp_addr[5:0], and dram_addr[14] is bit 3 of the adjusted nibble (R7, R8).
- R4: In a teletext fetch, dram_addr[6] equals disp_addr[6] XOR (NOT phase_1m).
- R5: In a teletext fetch, scan_row and disp_addr[10] have no effect on dram_addr.
- R6: A slot with phase_2m high and disp_addr[13] low is a bitmap fetch. In it, dram_addr[14:11] is the adjusted nibble, dram_addr[10:3] is disp_addr[7:0] and dram_addr[2:0] is scan_row.
- R7: The adjusted nibble is disp_addr[11:8] plus a bias plus 1, taken modulo 16. When disp_addr[12] is 0 the bias is 4'b1111, so the nibble equals disp_addr[11:8].
- R8: When disp_addr[12] is 1, size_sel sets the bias. 2'b00 gives 4'b0111 (subtract 0x4000), 2'b01 gives 4'b1011 (subtract 0x2000), 2'b10 gives 4'b0101 (subtract 0x5000) and 2'b11 gives 4'b1010 (subtract 0x2800).
- R9: dram_addr takes the value for the inputs present at a rising clk edge and holds it until the next edge.
- R10: With disp_addr[12] low, teletext fetches fall in 0x7C00..0x7FFF when disp_addr[11] is 1, and in 0x3C00..0x3FFF when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock (one edge per memory slot) |
| rst_n | input | 1 | Asynchronous reset, active low |
| phase_2m | input | 1 | 2 MHz phase: low selects a CPU slot, high selects a display slot |
| phase_1m | input | 1 | 1 MHz phase, used to flip one teletext address bit |
| cpu_addr | input | 15 | Processor address |
| disp_addr | input | 14 | Display controller character address |
| scan_row | input | 3 | Scanline counter within the character row |
| size_sel | input | 2 | Display area size code for the wrap correction |
| dram_addr | output | 15 | Registered DRAM address for the current slot |

## Verification
The bench builds the block with its default widths: a 15-bit DRAM address, a 14-bit character address, a 3-bit scanline field and a 4-bit nibble adder. These are the only widths at which the teletext field positions and the four bias values have a meaning. With them, every size code can be driven both with and without the overflow bit, and both screens of the teletext window can be reached. The toggled bit can be driven under both 1 MHz phases. Random vectors then mix all three slot kinds, and the scoreboard shows that each registered address is for the slot that was just driven.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  typedef enum logic [1:0] {
    SLOT_CPU = 2'd0,
    SLOT_TTX = 2'd1,
    SLOT_BMP = 2'd2
  } slot_kind_t;

  // Bias added to the upper display nibble (with carry-in 1).
  function automatic logic [3:0] wrap_bias(input logic ovf, input logic [1:0] sel);
    logic [3:0] b;
    if (!ovf) b = 4'b1111;
    else begin
      case (sel)
        2'b00:   b = 4'b0111;
        2'b01:   b = 4'b1011;
        2'b10:   b = 4'b0101;
        default: b = 4'b1010;
      endcase
    end
    return b;
  endfunction

endpackage

// File: rtl/xlate_wrap.sv
module xlate_wrap #(
  parameter int NIB_W = 4
) (
  input  logic [NIB_W-1:0] ma_nib,
  input  logic             ovf,
  input  logic [1:0]       size_sel,
  output logic [NIB_W-1:0] aa
);
  import xlate_pkg::*;

  logic [NIB_W-1:0] bias;
  logic [NIB_W:0]   sum;

  always_comb begin
    bias = NIB_W'(wrap_bias(ovf, size_sel));
    // carry-in of one turns the complemented bias into a subtraction
    sum  = {1'b0, ma_nib} + {1'b0, bias} + {{NIB_W{1'b0}}, 1'b1};
    aa   = sum[NIB_W-1:0];
  end

endmodule

// File: rtl/xlate_ttx.sv
module xlate_ttx #(
  parameter int AW      = 15,
  parameter int MW      = 14,
  parameter int WIN_W   = 10,
  parameter int FLIP_IX = 6
) (
  input  logic [MW-1:0] ma,
  input  logic          aa_msb,
  input  logic          phase_1m,
  output logic [AW-1:0] addr
);
  localparam int ONES_W = AW - 1 - WIN_W;

  logic [WIN_W-1:0] win;

  always_comb begin
    win          = ma[WIN_W-1:0];
    win[FLIP_IX] = ma[FLIP_IX] ^ ~phase_1m;
    addr         = {aa_msb, {ONES_W{1'b1}}, win};
  end

endmodule

// File: rtl/xlate_bmp.sv
module xlate_bmp #(
  parameter int AW    = 15,
  parameter int MW    = 14,
  parameter int RW    = 3,
  parameter int NIB_W = 4
) (
  input  logic [MW-1:0]    ma,
  input  logic [NIB_W-1:0] aa,
  input  logic [RW-1:0]    ra,
  output logic [AW-1:0]    addr
);
  localparam int LOW_W = AW - NIB_W - RW;

  assign addr = {aa, ma[LOW_W-1:0], ra};

endmodule

// File: rtl/vidmem_addr_xlate.sv
module vidmem_addr_xlate #(
  parameter int AW    = 15,
  parameter int MW    = 14,
  parameter int RW    = 3,
  parameter int NIB_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          phase_2m,
  input  logic          phase_1m,
  input  logic [AW-1:0] cpu_addr,
  input  logic [MW-1:0] disp_addr,
  input  logic [RW-1:0] scan_row,
  input  logic [1:0]    size_sel,
  output logic [AW-1:0] dram_addr
);
  import xlate_pkg::*;

  localparam int LOW_W  = AW - NIB_W - RW;
  localparam int NIB_LO = LOW_W;
  localparam int OVF_IX = LOW_W + NIB_W;
  localparam int SEL_IX = MW - 1;

  slot_kind_t       kind;
  logic [NIB_W-1:0] aa;
  logic [AW-1:0]    ttx_addr, bmp_addr, next_addr;

  xlate_wrap #(.NIB_W(NIB_W)) u_wrap (
    .ma_nib   (disp_addr[NIB_LO +: NIB_W]),
    .ovf      (disp_addr[OVF_IX]),
    .size_sel (size_sel),
    .aa       (aa)
  );

  xlate_ttx #(.AW(AW), .MW(MW)) u_ttx (
    .ma       (disp_addr),
    .aa_msb   (aa[NIB_W-1]),
    .phase_1m (phase_1m),
    .addr     (ttx_addr)
  );

  xlate_bmp #(.AW(AW), .MW(MW), .RW(RW), .NIB_W(NIB_W)) u_bmp (
    .ma   (disp_addr),
    .aa   (aa),
    .ra   (scan_row),
    .addr (bmp_addr)
  );

  always_comb begin
    if (!phase_2m)               kind = SLOT_CPU;
    else if (disp_addr[SEL_IX])  kind = SLOT_TTX;
    else                         kind = SLOT_BMP;
    case (kind)
      SLOT_TTX: next_addr = ttx_addr;
      SLOT_BMP: next_addr = bmp_addr;
      default:  next_addr = cpu_addr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dram_addr <= '0;
    else        dram_addr <= next_addr;
  end

  // R2
  cpu_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_2m |=> dram_addr == $past(cpu_addr));

  // R3
  ttx_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_2m && disp_addr[SEL_IX]) |=> dram_addr[AW-2:10] == '1);

  // R6
  bmp_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_2m && !disp_addr[SEL_IX]) |=> dram_addr[RW-1:0] == $past(scan_row));

  // R7
  nowrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_addr[OVF_IX] |-> aa == disp_addr[NIB_LO +: NIB_W]);

  // R8
  wrap_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_addr[OVF_IX] |-> aa != disp_addr[NIB_LO +: NIB_W]);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> dram_addr == $past(next_addr));

endmodule

// File: tb/vidmem_addr_xlate_bench.sv
module vidmem_addr_xlate_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phase_2m = 1'b0, phase_1m = 1'b0;
  logic [14:0] cpu_addr = '0;
  logic [13:0] disp_addr = '0;
  logic [2:0]  scan_row = '0;
  logic [1:0]  size_sel = '0;
  logic [14:0] dram_addr;

  int checks = 0, errors = 0;
  logic [14:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #2 clk = ~clk;

  vidmem_addr_xlate u_vidmem_addr_xlate (
    .clk(clk), .rst_n(rst_n), .phase_2m(phase_2m), .phase_1m(phase_1m),
    .cpu_addr(cpu_addr), .disp_addr(disp_addr), .scan_row(scan_row),
    .size_sel(size_sel), .dram_addr(dram_addr)
  );

  function automatic logic [3:0] model_nib(logic [13:0] ma, logic [1:0] sel);
    logic [3:0] b;
    if (!ma[12]) b = 4'hF;
    else case (sel)
      2'b00: b = 4'h7; 2'b01: b = 4'hB; 2'b10: b = 4'h5; default: b = 4'hA;
    endcase
    return ma[11:8] + b + 4'd1;
  endfunction

  function automatic logic [14:0] model(logic p2, logic p1, logic [14:0] a,
                                        logic [13:0] ma, logic [2:0] ra, logic [1:0] sel);
    logic [3:0] n;
    n = model_nib(ma, sel);
    if (!p2) return a;
    if (ma[13]) return {n[3], 4'hF, ma[9:7], ma[6] ^ ~p1, ma[5:0]};
    return {n, ma[7:0], ra};
  endfunction

  task automatic check(string tag, logic [14:0] act, logic [14:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // driver: drive at negedge, push expected
  task automatic slot(string tag, logic p2, logic p1, logic [14:0] a,
                      logic [13:0] ma, logic [2:0] ra, logic [1:0] sel);
    @(negedge clk);
    phase_2m = p2; phase_1m = p1; cpu_addr = a;
    disp_addr = ma; scan_row = ra; size_sel = sel;
    exp_q.push_back(model(p2, p1, a, ma, ra, sel));
    tag_q.push_back(tag);
  endtask

  // monitor: sample just after the edge that latched the slot
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [14:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, dram_addr, e);
      end
    end
  end

  logic [14:0] hold_val;

  initial begin
    #5;
    check("R1 reset", dram_addr, 15'h0);
    @(negedge clk); rst_n = 1'b1;

    slot("R2 cpu", 1'b0, 1'b0, 15'h1234, 14'h3FFF, 3'd7, 2'b11);
    slot("R2 cpu", 1'b0, 1'b1, 15'h7FFF, 14'h2000, 3'd0, 2'b00);
    slot("R2 cpu", 1'b0, 1'b0, 15'h0000, 14'h1555, 3'd5, 2'b01);
    // teletext screens, R10 and R3
    slot("R10 hi screen", 1'b1, 1'b1, 15'h0, 14'h2ABC, 3'd0, 2'b00);
    slot("R10 lo screen", 1'b1, 1'b1, 15'h0, 14'h2123, 3'd0, 2'b00);
    slot("R3 ttx", 1'b1, 1'b0, 15'h0, 14'h29C7, 3'd2, 2'b10);
    // R4 toggle bit under both phases
    slot("R4 p1=0", 1'b1, 1'b0, 15'h0, 14'h2840, 3'd0, 2'b00);
    slot("R4 p1=1", 1'b1, 1'b1, 15'h0, 14'h2840, 3'd0, 2'b00);
    // R5 scan_row and bit 10 ignored: expect same address
    slot("R5 base", 1'b1, 1'b1, 15'h0, 14'h2A55, 3'd0, 2'b00);
    slot("R5 row", 1'b1, 1'b1, 15'h0, 14'h2A55, 3'd6, 2'b00);
    slot("R5 bit10", 1'b1, 1'b1, 15'h0, 14'h2E55, 3'd3, 2'b00);
    // R6/R7 bitmap without overflow
    slot("R6 bmp", 1'b1, 1'b0, 15'h0, 14'h0A5C, 3'd5, 2'b10);
    slot("R7 nowrap", 1'b1, 1'b1, 15'h0, 14'h0FFF, 3'd7, 2'b00);
    // R8 each size code with overflow
    for (int s = 0; s < 4; s++)
      slot("R8 wrap", 1'b1, 1'b0, 15'h0, 14'h1F37, 3'd1, 2'(s));
    for (int s = 0; s < 4; s++)
      slot("R8 wrap0", 1'b1, 1'b0, 15'h0, 14'h1000, 3'd0, 2'(s));
    // mixed random traffic
    for (int i = 0; i < 300; i++)
      slot("R9 mix", 1'($urandom), 1'($urandom), 15'($urandom),
           14'($urandom), 3'($urandom), 2'($urandom));
    @(posedge clk); #1;
    // R9 hold: output stays while no edge occurs
    hold_val = dram_addr;
    @(negedge clk);
    cpu_addr = ~cpu_addr; disp_addr = ~disp_addr; phase_2m = ~phase_2m;
    #1;
    check("R9 hold", dram_addr, hold_val);
    // R1 reset again mid-run
    rst_n = 1'b0; #1;
    check("R1 async reset", dram_addr, 15'h0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule